// File: doc/BRIEF.md
# Field-Gated Two-Toggle Pulse Generator

This block makes one programmable pulse inside a raster-style frame. It keeps its own pixel, line and field counters, moved along by a line-start strobe and a field-start strobe. The pulse begins each field at a programmed level. It inverts at two programmed positions, each given as a (line, pixel) pair. It is live only in one selected field of a repeating field sequence, and only while a pulse-enable input is set. In every other case it rests at the programmed start level.

The pulse can go to a sync output, which is gated by a sync-output enable. It can instead go to a substrate-clear output, where a route bit picks it in place of an incoming substrate-clear waveform. A combine bit XORs the pulse with that incoming waveform, so the toggles of the two signals add up to one output with more edges. All configuration arrives on plain input ports.

Top module: `fieldPulseGen`

## Requirements
- R1: After reset the pixel, line and field counters are 0 and the pulse level equals `startPol`.
- R2: The pixel counter increments every clock and returns to 0 in the cycle after `lineStart` or `fieldStart`. The line counter returns to 0 after `fieldStart` and increments after a `lineStart` that has no `fieldStart` with it.
- R3: The 3-bit field counter advances on each `fieldStart` and wraps to 0 after reaching `fieldLast`. The sequence length is `fieldLast`+1, from 1 to 8 fields.
- R4: In an armed field, a cycle whose pixel and line counters equal a toggle position inverts the pulse level, starting in the following cycle.
- R5: The pulse is armed only while `pulseEn`=1 and the field counter equals `fieldSel`. When it is not armed, the pulse level equals `startPol`.
- R6: When both toggle positions are equal, the two inversions cancel and the level stays at `startPol`.
- R7: In the cycle after `fieldStart`, the pulse level is `startPol`, whatever state the previous field left.
- R8: `syncOut` equals the pulse level when `syncOutEn`=1 and `routeSub`=0; otherwise it is 0.
- R9: With `routeSub`=1 and `combineSub`=0, `subOut` equals the pulse level.
- R10: With `combineSub`=1, `subOut` equals `subIn` XOR the pulse level, whatever `routeSub` is.
- R11: With `routeSub`=0 and `combineSub`=0, `subOut` equals `subIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineStart | input | 1 | Line-start strobe |
| fieldStart | input | 1 | Field-start strobe |
| fieldLast | input | 3 | Last field index of the sequence (length minus 1) |
| fieldSel | input | 3 | Field index that carries the pulse |
| pulseEn | input | 1 | Pulse enable |
| startPol | input | 1 | Level at field start |
| tog1Line | input | 12 | First toggle line |
| tog1Pix | input | 13 | First toggle pixel |
| tog2Line | input | 12 | Second toggle line |
| tog2Pix | input | 13 | Second toggle pixel |
| syncOutEn | input | 1 | Sync output enable |
| routeSub | input | 1 | Send pulse to substrate-clear output |
| combineSub | input | 1 | XOR pulse with incoming substrate-clear waveform |
| subIn | input | 1 | Incoming substrate-clear waveform |
| syncOut | output | 1 | Sync output |
| subOut | output | 1 | Substrate-clear output |

## Verification
The assertions check the following on every cycle:
- the output selection for the sync, pass-through, route and XOR cases;
- the rest level while the pulse is disabled;
- counter clearing after the line and field strobes;
- the field counter wrap;
- the reload of the pulse level at field start.

Only the bench scenarios can show the following:
- that edges land at the right (line, pixel) position;
- that the pulse appears only in the selected field;
- that coincident toggles cancel;
- that an unreached second toggle is cleaned up by the next field.

These scenarios are compared against a bench model over random frame geometries and configurations.

// File: rtl/fpgPkg.sv
package fpgPkg;
  typedef struct packed {
    logic clearPix;
    logic clearLine;
    logic stepLine;
    logic reloadPulse;
    logic armed;
  } fpgStrobes_t;
endpackage

// File: rtl/fpgControl.sv
module fpgControl
  import fpgPkg::*;
#(
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineStart,
  input  logic               fieldStart,
  input  logic [FIELD_W-1:0] fieldLast,
  input  logic [FIELD_W-1:0] fieldSel,
  input  logic               pulseEn,
  output fpgStrobes_t        strobes,
  output logic [FIELD_W-1:0] fieldCnt
);
  logic [FIELD_W-1:0] fieldNext;

  always_comb begin
    fieldNext = (fieldCnt == fieldLast) ? '0 : fieldCnt + FIELD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldCnt <= '0;
    end else if (fieldStart) begin
      fieldCnt <= fieldNext;
    end
  end

  always_comb begin
    strobes.clearPix    = lineStart | fieldStart;
    strobes.clearLine   = fieldStart;
    strobes.stepLine    = lineStart & ~fieldStart;
    strobes.reloadPulse = fieldStart;
    strobes.armed       = pulseEn & (fieldCnt == fieldSel);
  end
endmodule

// File: rtl/fpgDatapath.sv
module fpgDatapath
  import fpgPkg::*;
#(
  parameter int PIX_W   = 13,
  parameter int LINE_W  = 12,
  parameter int NUM_TOG = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  fpgStrobes_t                    strobes,
  input  logic                           startPol,
  input  logic [NUM_TOG-1:0][LINE_W-1:0] togLine,
  input  logic [NUM_TOG-1:0][PIX_W-1:0]  togPix,
  output logic [PIX_W-1:0]               pixCnt,
  output logic [LINE_W-1:0]              lineCnt,
  output logic                           pulseState,
  output logic                           pulseLevel
);
  logic [NUM_TOG-1:0] hit;
  logic               flip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt <= '0;
    end else if (strobes.clearPix) begin
      pixCnt <= '0;
    end else begin
      pixCnt <= pixCnt + PIX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt <= '0;
    end else if (strobes.clearLine) begin
      lineCnt <= '0;
    end else if (strobes.stepLine) begin
      lineCnt <= lineCnt + LINE_W'(1);
    end
  end

  for (genvar t = 0; t < NUM_TOG; t++) begin : gTog
    assign hit[t] = (lineCnt == togLine[t]) && (pixCnt == togPix[t]);
  end

  assign flip = ^hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseState <= 1'b0;
    end else if (strobes.reloadPulse) begin
      pulseState <= startPol;
    end else if (strobes.armed) begin
      pulseState <= pulseState ^ flip;
    end
  end

  assign pulseLevel = strobes.armed ? pulseState : startPol;
endmodule

// File: rtl/fpgRoute.sv
module fpgRoute (
  input  logic pulseLevel,
  input  logic syncOutEn,
  input  logic routeSub,
  input  logic combineSub,
  input  logic subIn,
  output logic syncOut,
  output logic subOut
);
  logic subPick;

  always_comb begin
    syncOut = (syncOutEn && !routeSub) ? pulseLevel : 1'b0;
    subPick = routeSub ? pulseLevel : subIn;
    subOut  = combineSub ? (subIn ^ pulseLevel) : subPick;
  end
endmodule

// File: rtl/fieldPulseGen.sv
module fieldPulseGen
  import fpgPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStart,
  input  logic        fieldStart,
  input  logic [2:0]  fieldLast,
  input  logic [2:0]  fieldSel,
  input  logic        pulseEn,
  input  logic        startPol,
  input  logic [11:0] tog1Line,
  input  logic [12:0] tog1Pix,
  input  logic [11:0] tog2Line,
  input  logic [12:0] tog2Pix,
  input  logic        syncOutEn,
  input  logic        routeSub,
  input  logic        combineSub,
  input  logic        subIn,
  output logic        syncOut,
  output logic        subOut
);
  localparam int PIX_W   = 13;
  localparam int LINE_W  = 12;
  localparam int FIELD_W = 3;
  localparam int NUM_TOG = 2;

  fpgStrobes_t                    strobes;
  logic [FIELD_W-1:0]             fieldCnt;
  logic [PIX_W-1:0]               pixCnt;
  logic [LINE_W-1:0]              lineCnt;
  logic                           pulseState;
  logic                           pulseLevel;
  logic [NUM_TOG-1:0][LINE_W-1:0] togLine;
  logic [NUM_TOG-1:0][PIX_W-1:0]  togPix;

  assign togLine = {tog2Line, tog1Line};
  assign togPix  = {tog2Pix, tog1Pix};

  fpgControl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .fieldStart(fieldStart),
    .fieldLast(fieldLast), .fieldSel(fieldSel), .pulseEn(pulseEn),
    .strobes(strobes), .fieldCnt(fieldCnt)
  );

  fpgDatapath #(.PIX_W(PIX_W), .LINE_W(LINE_W), .NUM_TOG(NUM_TOG)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startPol(startPol),
    .togLine(togLine), .togPix(togPix), .pixCnt(pixCnt), .lineCnt(lineCnt),
    .pulseState(pulseState), .pulseLevel(pulseLevel)
  );

  fpgRoute u_route (
    .pulseLevel(pulseLevel), .syncOutEn(syncOutEn), .routeSub(routeSub),
    .combineSub(combineSub), .subIn(subIn), .syncOut(syncOut), .subOut(subOut)
  );
endmodule

// File: rtl/fieldPulseGenChecker.sv
module fieldPulseGenChecker (
  input logic        clk,
  input logic        rstN,
  input logic        lineStart,
  input logic        fieldStart,
  input logic [2:0]  fieldLast,
  input logic        pulseEn,
  input logic        startPol,
  input logic        syncOutEn,
  input logic        routeSub,
  input logic        combineSub,
  input logic        subIn,
  input logic        syncOut,
  input logic        subOut,
  input logic [2:0]  fieldCnt,
  input logic [12:0] pixCnt,
  input logic [11:0] lineCnt,
  input logic        pulseState,
  input logic        pulseLevel
);
  AST_SYNC_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!syncOutEn || routeSub) |-> !syncOut); // R8
  AST_SYNC_CARRIES: assert property (@(posedge clk) disable iff (!rstN)
    (syncOutEn && !routeSub) |-> syncOut == pulseLevel); // R8
  AST_SUB_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (!combineSub && !routeSub) |-> subOut == subIn); // R11
  AST_SUB_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (routeSub && !combineSub) |-> subOut == pulseLevel); // R9
  AST_SUB_XOR: assert property (@(posedge clk) disable iff (!rstN)
    combineSub |-> subOut == (subIn ^ pulseLevel)); // R10
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !pulseEn |-> pulseLevel == startPol); // R5
  AST_PIX_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart || fieldStart) |=> pixCnt == '0); // R2
  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |=> lineCnt == '0); // R2
  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (fieldStart && fieldCnt == fieldLast) |=> fieldCnt == 3'd0); // R3
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fieldStart |=> $stable(fieldCnt)); // R3
  AST_RELOAD_POL: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |=> pulseState == $past(startPol)); // R7
endmodule

bind fieldPulseGen fieldPulseGenChecker u_chk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .fieldStart(fieldStart),
  .fieldLast(fieldLast), .pulseEn(pulseEn), .startPol(startPol),
  .syncOutEn(syncOutEn), .routeSub(routeSub), .combineSub(combineSub),
  .subIn(subIn), .syncOut(syncOut), .subOut(subOut), .fieldCnt(fieldCnt),
  .pixCnt(pixCnt), .lineCnt(lineCnt), .pulseState(pulseState),
  .pulseLevel(pulseLevel)
);

// File: tb/fieldPulseGen_tb.sv
module fieldPulseGen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStart = 1'b0, fieldStart = 1'b0;
  logic [2:0] fieldLast = 3'd0, fieldSel = 3'd0;
  logic pulseEn = 1'b0, startPol = 1'b0;
  logic [11:0] tog1Line = '0, tog2Line = '0;
  logic [12:0] tog1Pix = '0, tog2Pix = '0;
  logic syncOutEn = 1'b0, routeSub = 1'b0, combineSub = 1'b0, subIn = 1'b0;
  logic syncOut, subOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  // bench model state
  logic [12:0] mPix = '0;
  logic [11:0] mLine = '0;
  logic [2:0]  mField = '0;
  logic        mPulse = 1'b0;
  int          toggleSeen = 0;

  always #2.5 clk = ~clk;

  fieldPulseGen u_dut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .fieldStart(fieldStart),
    .fieldLast(fieldLast), .fieldSel(fieldSel), .pulseEn(pulseEn),
    .startPol(startPol), .tog1Line(tog1Line), .tog1Pix(tog1Pix),
    .tog2Line(tog2Line), .tog2Pix(tog2Pix), .syncOutEn(syncOutEn),
    .routeSub(routeSub), .combineSub(combineSub), .subIn(subIn),
    .syncOut(syncOut), .subOut(subOut)
  );

  function automatic logic expLevel();
    return (pulseEn && mField == fieldSel) ? mPulse : startPol;
  endfunction

  function automatic logic expSync();
    return (syncOutEn && !routeSub) ? expLevel() : 1'b0;
  endfunction

  function automatic logic expSub();
    if (combineSub) return subIn ^ expLevel();
    if (routeSub) return expLevel();
    return subIn;
  endfunction

  task automatic check(input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, name, act, exp);
    end
  endtask

  // called just after a falling edge; compares outputs, then advances one cycle
  task automatic tick(input logic ls, input logic fs);
    logic h1, h2, armed;
    lineStart  = ls;
    fieldStart = fs;
    subIn      = 1'($urandom);
    #1;
    check("syncOut", syncOut, expSync());
    check("subOut", subOut, expSub());
    armed = pulseEn && (mField == fieldSel);
    h1 = (mLine == tog1Line) && (mPix == tog1Pix);
    h2 = (mLine == tog2Line) && (mPix == tog2Pix);
    @(posedge clk);
    if (fs) mPulse = startPol;
    else if (armed && (h1 ^ h2)) begin
      mPulse = ~mPulse;
      toggleSeen++;
    end
    mPix = (ls || fs) ? 13'd0 : mPix + 13'd1;
    if (fs) mLine = 12'd0;
    else if (ls) mLine = mLine + 12'd1;
    if (fs) mField = (mField == fieldLast) ? 3'd0 : mField + 3'd1;
    @(negedge clk);
  endtask

  task automatic runField(input int lines, input int lineLen);
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < lineLen; p++)
        tick(p == 0, (l == 0) && (p == 0));
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    syncOutEn = 1'b1;
    startPol  = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, pulse disabled, level follows startPol
    tag = "R1";
    #1;
    check("syncOut reset", syncOut, 1'b1);
    check("subOut reset", subOut, subIn);
    @(negedge clk);

    // R4: directed toggle placement, one field sequence of length 2, field 1 selected
    tag = "R4";
    fieldLast = 3'd1; fieldSel = 3'd1; pulseEn = 1'b1; startPol = 1'b0;
    tog1Line = 12'd1; tog1Pix = 13'd3; tog2Line = 12'd2; tog2Pix = 13'd5;
    toggleSeen = 0;
    runField(4, 10);   // field 1 after first strobe
    check("two toggles seen", 1'(toggleSeen == 2), 1'b1);
    tag = "R5";        // next field is 0: not selected, must rest
    toggleSeen = 0;
    runField(4, 10);
    check("no toggle in other field", 1'(toggleSeen == 0), 1'b1);

    // R6: equal positions cancel
    tag = "R6";
    tog2Line = tog1Line; tog2Pix = tog1Pix;
    runField(4, 10);
    runField(4, 10);
    // R7: second toggle never reached, next field reloads
    tag = "R7";
    tog2Line = 12'd50; startPol = 1'b1;
    runField(4, 10);
    runField(4, 10);
    // R9, R10, R11 and R8 with the pulse active
    tog2Line = 12'd2;
    tag = "R9";  routeSub = 1'b1; runField(3, 10); runField(3, 10);
    tag = "R10"; combineSub = 1'b1; runField(3, 10); runField(3, 10);
    routeSub = 1'b0; runField(3, 10); runField(3, 10);
    tag = "R11"; combineSub = 1'b0; runField(3, 10); runField(3, 10);
    tag = "R8";  syncOutEn = 1'b0; runField(3, 10); runField(3, 10);
    syncOutEn = 1'b1;
    // R3: full 8-field sequence, pulse only in field 7
    tag = "R3";
    fieldLast = 3'd7; fieldSel = 3'd7;
    for (int f = 0; f < 10; f++) runField(3, 10);

    // R2: random geometries and configurations
    tag = "R2";
    for (int f = 0; f < 120; f++) begin
      int lines, len;
      lines = 2 + int'($urandom_range(0, 6));
      len   = 4 + int'($urandom_range(0, 30));
      fieldLast  = 3'($urandom_range(0, 7));
      fieldSel   = 3'($urandom_range(0, 7));
      pulseEn    = ($urandom_range(0, 3) != 0);
      startPol   = 1'($urandom);
      tog1Line   = 12'($urandom_range(0, lines));
      tog2Line   = 12'($urandom_range(0, lines));
      tog1Pix    = 13'($urandom_range(0, len));
      tog2Pix    = 13'($urandom_range(0, len));
      syncOutEn  = ($urandom_range(0, 3) != 0);
      routeSub   = 1'($urandom);
      combineSub = 1'($urandom);
      runField(lines, len);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule